// File: doc/BRIEF.md
# I2C SCL Waveform and SDA Hold Timer

This block sets the bus timing for an I2C master. The master engine raises an enable input. While that input is high the block drives the SCL line through a timed low phase and a timed high phase, one after the other. Each phase lasts a programmed divider value shifted left by a common exponent, plus three peripheral clocks. After every falling edge of SCL, a separate countdown marks the cycle in which SDA may change. That cycle comes a programmed hold value plus three clocks after the fall. The block emits a one-cycle tick at the start of each phase, so the byte engine can step its bit sequencing in lock with the line.

Configuration arrives as single-cycle 32-bit register writes. One register holds the waveform fields. A second register carries a 24-bit key. A matching write either locks or unlocks the waveform register. A write made while the register is locked is dropped and raises a sticky violation flag. During the high phase, the block senses the SCL line. If another device holds the line low, the high-phase count pauses until the line reads high again.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and whenever `gen_en` is low, `scl_out` is 1 (released), `phase_tick` and `sda_strobe` are 0. After reset, `wp_active` and `wp_violation` are 0 and every waveform field is 0.
- R2: The waveform register is at address 0x10. Low divider is bits 7:0 and exponent is bits 18:16. Each low phase drives `scl_out` to 0 for exactly (low << exponent) + 3 clock cycles.
- R3: The high divider is bits 15:8. When the sensed SCL stays high, each high phase holds `scl_out` at 1 for exactly (high << exponent) + 3 cycles and then falls.
- R4: A high-phase cycle in which the sensed SCL is low is not counted. The high phase is extended by exactly the number of such cycles.
- R5: `phase_tick` is 1 for exactly the first cycle of every low and every high phase, including the first low phase after `gen_en` rises. It is 0 otherwise.
- R6: The hold field is bits 28:24. `sda_strobe` pulses for one cycle, (hold + 3) cycles after the first low cycle of SCL, using the hold value present during that first low cycle.
- R7: The protection register is at address 0xE4. A write whose bits 31:8 equal 0x545749 sets `wp_active` to that write's bit 0. A write with any other key leaves `wp_active` unchanged.
- R8: While `wp_active` is 1, a write to address 0x10 leaves the waveform unchanged and sets `wp_violation`. A valid key write clears `wp_violation`.
- R9: Phase and hold lengths are loaded only at a phase boundary. A waveform write changes the timing of the next phase, not of the current one.
- R10: When `gen_en` falls, the next cycle shows `scl_out` 1 with no tick. Any pending `sda_strobe` is cancelled, and a later enable starts again with a full low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| gen_en | input | 1 | Run request from the master engine |
| scl_in | input | 1 | Sensed SCL line level |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| phase_tick | output | 1 | First cycle of each SCL phase |
| sda_strobe | output | 1 | Cycle in which SDA may change |
| wp_active | output | 1 | Waveform register is locked |
| wp_violation | output | 1 | A locked write was attempted |

## Verification
A wrong phase-counter load or decrement shows at `scl_out` and `phase_tick` on the first boundary after the fault. That is at most one phase length later, so the cycle-by-cycle model catches it within a few hundred clocks even at the largest exponent exercised. A stuck or misloaded hold countdown shows as a `sda_strobe` pulse one or more cycles off inside the same low phase. A wrong lock state shows at once on `wp_active`. It also shows at the next phase, because a dropped or accepted waveform write changes that phase's length. Stretching is driven in the middle of a high phase, so a counter that keeps counting while SCL is held low makes SCL fall early by exactly the stretch length.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
   localparam logic [7:0]  WAVE_ADDR = 8'h10;
   localparam logic [7:0]  LOCK_ADDR = 8'hE4;
   localparam logic [23:0] LOCK_KEY  = 24'h545749;

   localparam int LO_POS   = 0;
   localparam int HI_POS   = 8;
   localparam int EXP_POS  = 16;
   localparam int HOLD_POS = 24;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
   import scl_gen_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DIV_W  = 8,
   parameter int EXP_W  = 3,
   parameter int HOLD_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   output logic [DIV_W-1:0]  lo_div,
   output logic [DIV_W-1:0]  hi_div,
   output logic [EXP_W-1:0]  exp_sel,
   output logic [HOLD_W-1:0] hold_val,
   output logic              lock_q,
   output logic              viol_q
);
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("DIV_W must be 1..8");
   end
   if (EXP_W < 1 || EXP_W > 3) begin : g_bad_exp
      $error("EXP_W must be 1..3");
   end
   if (HOLD_W < 1 || HOLD_W > 5) begin : g_bad_hold
      $error("HOLD_W must be 1..5");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end

   logic hit_wave, hit_lock, key_ok;

   assign hit_wave = wr_en && (wr_addr == ADDR_W'(WAVE_ADDR));
   assign hit_lock = wr_en && (wr_addr == ADDR_W'(LOCK_ADDR));
   assign key_ok   = (wr_data[31:8] == LOCK_KEY);

   logic unused_wdata;
   assign unused_wdata = ^{wr_data[31:29], wr_data[23:19]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_div   <= '0;
         hi_div   <= '0;
         exp_sel  <= '0;
         hold_val <= '0;
         lock_q   <= 1'b0;
         viol_q   <= 1'b0;
      end else begin
         if (hit_lock && key_ok) begin
            lock_q <= wr_data[0];
            viol_q <= 1'b0;
         end
         if (hit_wave) begin
            if (lock_q) begin
               viol_q <= 1'b1;
            end else begin
               lo_div   <= wr_data[LO_POS   +: DIV_W];
               hi_div   <= wr_data[HI_POS   +: DIV_W];
               exp_sel  <= wr_data[EXP_POS  +: EXP_W];
               hold_val <= wr_data[HOLD_POS +: HOLD_W];
            end
         end
      end
   end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
   import scl_gen_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int EXP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             line_hi,
   input  logic [DIV_W-1:0] lo_div,
   input  logic [DIV_W-1:0] hi_div,
   input  logic [EXP_W-1:0] exp_sel,
   output logic             scl_q,
   output logic             tick_q,
   output logic             fall_first
);
   localparam int CNT_W = DIV_W + (1 << EXP_W) + 1;

   phase_e               ph;
   logic [CNT_W-1:0]     remain;
   logic [CNT_W-1:0]     lo_load, hi_load;

   // Loaded value is the phase length minus one: (div << exp) + 2.
   assign lo_load = (CNT_W'(lo_div) << exp_sel) + CNT_W'(2);
   assign hi_load = (CNT_W'(hi_div) << exp_sel) + CNT_W'(2);

   assign fall_first = tick_q && !scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         remain <= '0;
         scl_q  <= 1'b1;
         tick_q <= 1'b0;
      end else begin
         tick_q <= 1'b0;
         if (!run) begin
            ph     <= PH_IDLE;
            scl_q  <= 1'b1;
            remain <= '0;
         end else begin
            unique case (ph)
               PH_IDLE: begin
                  ph     <= PH_LOW;
                  remain <= lo_load;
                  scl_q  <= 1'b0;
                  tick_q <= 1'b1;
               end
               PH_LOW: begin
                  if (remain == '0) begin
                     ph     <= PH_HIGH;
                     remain <= hi_load;
                     scl_q  <= 1'b1;
                     tick_q <= 1'b1;
                  end else begin
                     remain <= remain - 1'b1;
                  end
               end
               PH_HIGH: begin
                  if (line_hi) begin
                     if (remain == '0) begin
                        ph     <= PH_LOW;
                        remain <= lo_load;
                        scl_q  <= 1'b0;
                        tick_q <= 1'b1;
                     end else begin
                        remain <= remain - 1'b1;
                     end
                  end
               end
               default: begin
                  ph    <= PH_IDLE;
                  scl_q <= 1'b1;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/sda_hold_timer.sv
module sda_hold_timer #(
   parameter int HOLD_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              fall_first,
   input  logic [HOLD_W-1:0] hold_val,
   output logic              strobe_q
);
   localparam int HC_W = HOLD_W + 2;

   logic            armed;
   logic [HC_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         left     <= '0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= 1'b0;
         if (!run) begin
            armed <= 1'b0;
            left  <= '0;
         end else if (fall_first) begin
            // Loaded at the end of the first low cycle; fires hold+3 after it began.
            armed <= 1'b1;
            left  <= HC_W'(hold_val) + HC_W'(1);
         end else if (armed) begin
            if (left == '0) begin
               strobe_q <= 1'b1;
               armed    <= 1'b0;
            end else begin
               left <= left - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
   parameter int ADDR_W      = 8,
   parameter int DIV_W       = 8,
   parameter int EXP_W       = 3,
   parameter int HOLD_W      = 5,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              gen_en,
   input  logic              scl_in,
   output logic              scl_out,
   output logic              phase_tick,
   output logic              sda_strobe,
   output logic              wp_active,
   output logic              wp_violation
);
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0..4");
   end

   logic [DIV_W-1:0]  lo_div, hi_div;
   logic [EXP_W-1:0]  exp_sel;
   logic [HOLD_W-1:0] hold_val;
   logic              scl_sensed;
   logic              fall_first;

   if (SYNC_STAGES == 0) begin : g_direct
      assign scl_sensed = scl_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-1:0], scl_in} >> 0;
      end
      assign scl_sensed = sync_q[SYNC_STAGES-1];
   end

   scl_cfg_regs #(
      .ADDR_W (ADDR_W),
      .DIV_W  (DIV_W),
      .EXP_W  (EXP_W),
      .HOLD_W (HOLD_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .wr_addr  (reg_addr),
      .wr_data  (reg_wdata),
      .lo_div   (lo_div),
      .hi_div   (hi_div),
      .exp_sel  (exp_sel),
      .hold_val (hold_val),
      .lock_q   (wp_active),
      .viol_q   (wp_violation)
   );

   scl_phase_seq #(
      .DIV_W (DIV_W),
      .EXP_W (EXP_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (gen_en),
      .line_hi    (scl_sensed),
      .lo_div     (lo_div),
      .hi_div     (hi_div),
      .exp_sel    (exp_sel),
      .scl_q      (scl_out),
      .tick_q     (phase_tick),
      .fall_first (fall_first)
   );

   sda_hold_timer #(
      .HOLD_W (HOLD_W)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (gen_en),
      .fall_first (fall_first),
      .hold_val   (hold_val),
      .strobe_q   (sda_strobe)
   );
endmodule

module scl_timing_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic gen_en,
   input logic scl_sensed,
   input logic scl_out,
   input logic phase_tick,
   input logic sda_strobe,
   input logic wp_active,
   input logic wp_violation
);
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |=> (scl_out && !phase_tick && !sda_strobe)); // R10

   AST_TICK_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      phase_tick |-> (scl_out != $past(scl_out))); // R5

   AST_FALL_HAS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_out) |-> phase_tick); // R5

   AST_STROBE_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      sda_strobe |-> $past(gen_en)); // R6

   AST_VIOL_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wp_violation) |-> wp_active); // R8

   AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_en && $past(gen_en) && scl_out && !scl_sensed) |=> scl_out); // R4
endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .gen_en       (gen_en),
   .scl_sensed   (scl_sensed),
   .scl_out      (scl_out),
   .phase_tick   (phase_tick),
   .sda_strobe   (sda_strobe),
   .wp_active    (wp_active),
   .wp_violation (wp_violation)
);

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        gen_en = 1'b0;
   logic        stretch = 1'b0;
   logic        scl_in;
   logic        scl_out, phase_tick, sda_strobe, wp_active, wp_violation;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   assign scl_in = scl_out & ~stretch;

   scl_timing_gen dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr       (reg_wr),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .gen_en       (gen_en),
      .scl_in       (scl_in),
      .scl_out      (scl_out),
      .phase_tick   (phase_tick),
      .sda_strobe   (sda_strobe),
      .wp_active    (wp_active),
      .wp_violation (wp_violation)
   );

   // Behavioural reference: phase as a word, elapsed counted cycles, cycles since fall.
   int  m_lo, m_hi, m_ex, m_hold;
   bit  m_lock, m_viol;
   int  m_phase;          // 0 idle, 1 low, 2 high
   int  m_done, m_need;
   int  m_since;          // -1 when no hold countdown is running
   int  m_snap;
   bit  m_scl, m_tick, m_strobe;

   function automatic int plen(input int d, input int e);
      return d * (1 << e) + 3;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lo = 0; m_hi = 0; m_ex = 0; m_hold = 0;
         m_lock = 0; m_viol = 0;
         m_phase = 0; m_done = 0; m_need = 0;
         m_since = -1; m_snap = 0;
         m_scl = 1; m_tick = 0; m_strobe = 0;
      end else begin
         int o_lo, o_hi, o_ex, o_hold;
         o_lo = m_lo; o_hi = m_hi; o_ex = m_ex; o_hold = m_hold;
         // register writes
         if (reg_wr && reg_addr == 8'hE4 && reg_wdata[31:8] == 24'h545749) begin
            m_lock = reg_wdata[0];
            m_viol = 0;
         end
         if (reg_wr && reg_addr == 8'h10) begin
            if (m_lock) m_viol = 1;
            else begin
               m_lo = reg_wdata[7:0]; m_hi = reg_wdata[15:8];
               m_ex = reg_wdata[18:16]; m_hold = reg_wdata[28:24];
            end
         end
         m_tick = 0;
         m_strobe = 0;
         if (!gen_en) begin
            m_phase = 0; m_scl = 1; m_since = -1;
         end else begin
            if (m_since >= 0) begin
               m_since++;
               if (m_since == 1) m_snap = o_hold;
               if (m_since == m_snap + 3 && m_since > 1) begin
                  m_strobe = 1; m_since = -1;
               end
            end
            if (m_phase == 0) begin
               m_phase = 1; m_done = 0; m_need = plen(o_lo, o_ex);
               m_scl = 0; m_tick = 1; m_since = 0;
            end else if (m_phase == 1) begin
               m_done++;
               if (m_done >= m_need) begin
                  m_phase = 2; m_done = 0; m_need = plen(o_hi, o_ex);
                  m_scl = 1; m_tick = 1;
               end
            end else begin
               if (scl_in) m_done++;
               if (m_done >= m_need) begin
                  m_phase = 1; m_done = 0; m_need = plen(o_lo, o_ex);
                  m_scl = 0; m_tick = 1; m_since = 0;
               end
            end
         end
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s cycle %0d actual %0b expected %0b", tag, cycles, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         chk("R2 R3 R4 R9 R10 scl_out", scl_out, m_scl);
         chk("R5 phase_tick", phase_tick, m_tick);
         chk("R6 sda_strobe", sda_strobe, m_strobe);
         chk("R7 wp_active", wp_active, m_lock);
         chk("R8 wp_violation", wp_violation, m_viol);
      end
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog cycle %0d actual hung expected done", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   function automatic logic [31:0] wave(input int lo, input int hi, input int ex, input int hd);
      return (32'(hd) << 24) | (32'(ex) << 16) | (32'(hi) << 8) | 32'(lo);
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      idle(3);
      // R1: outputs while in reset
      chk("R1 reset scl_out", scl_out, 1'b1);
      chk("R1 reset phase_tick", phase_tick, 1'b0);
      chk("R1 reset wp_active", wp_active, 1'b0);
      rst_n = 1'b1;
      idle(4);
      chk("R1 idle scl_out", scl_out, 1'b1);
      chk("R1 idle sda_strobe", sda_strobe, 1'b0);
      chk("R1 idle wp_violation", wp_violation, 1'b0);

      // R2 R3 R5 R6: default fields (3/3 phases), then a programmed waveform
      gen_en = 1'b1;
      idle(20);
      wr(8'h10, wave(2, 1, 1, 2));
      idle(80);

      // R9: change in the middle of a phase
      wr(8'h10, wave(0, 3, 0, 0));
      idle(40);

      // R4: hold the line low in a high phase
      wr(8'h10, wave(4, 4, 0, 1));
      idle(20);
      while (!(scl_out && phase_tick)) @(negedge clk);
      idle(2);
      stretch = 1'b1;
      idle(6);
      stretch = 1'b0;
      idle(40);

      // R10: drop enable with a long hold pending
      wr(8'h10, wave(10, 2, 0, 31));
      idle(30);
      while (!(phase_tick && !scl_out)) @(negedge clk);
      idle(4);
      gen_en = 1'b0;
      idle(1);
      chk("R10 disable scl_out", scl_out, 1'b1);
      idle(50);
      gen_en = 1'b1;
      idle(60);

      // R7 R8: lock, locked write, wrong key, unlock
      wr(8'hE4, {24'h545749, 8'h01});
      chk("R7 lock set", wp_active, 1'b1);
      wr(8'h10, wave(1, 1, 0, 0));
      chk("R8 violation set", wp_violation, 1'b1);
      idle(60);
      wr(8'hE4, {24'h545748, 8'h00});
      chk("R7 wrong key ignored", wp_active, 1'b1);
      wr(8'hE4, {24'h545749, 8'h00});
      chk("R7 unlocked", wp_active, 1'b0);
      chk("R8 violation cleared", wp_violation, 1'b0);
      wr(8'h10, wave(1, 1, 0, 0));
      idle(40);

      // R2 R6: largest exponent and hold
      wr(8'h10, wave(1, 2, 7, 31));
      idle(800);
      gen_en = 1'b0;
      idle(5);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule